// File: doc/BRIEF.md
# Hot Basic Block Profiler

This block sits beside a processor pipeline and watches the stream of committed program-counter values. Whenever two consecutive valid PC values do not differ by exactly one instruction (four bytes), control flow must have left the straight-line path through a taken branch or a jump. The new PC is then the first address of a basic block. The profiler keeps a small fully associative table of such block start addresses, each with an execution counter. A block whose counter is larger than a threshold supplied at the port is reported as hot.

No branch or jump signal is taken from the core. The PC difference alone decides. A repeated identical PC therefore also counts as entering a block, for example in a loop that branches back to itself. Software or a debug path reads the table one entry at a time through an index port. Each read shows the entry's start address, its count and whether it is hot. When the table has no free slot left, new start addresses are discarded and a sticky overflow indication is raised.

Top module: `hbb_profiler`

## Requirements
- R1: After reset every table entry reads as invalid with address 0 and count 0, `rd_hot` is 0 and `overflow` is 0.
- R2: A valid PC equal to the previous valid PC plus 4 changes no entry. A cycle with `pc_valid` low changes no entry and does not replace the remembered previous PC.
- R3: The first valid PC after reset never changes the table, whatever its value.
- R4: A valid PC that differs from previous-PC-plus-4 and matches no valid entry is written into the lowest-numbered invalid entry, with count 1. The update is visible on the read port after the clock edge that samples the PC.
- R5: A valid PC that differs from previous-PC-plus-4 and matches a valid entry's address adds 1 to that entry's count.
- R6: A count at its maximum value (all ones, CNT_W bits) stays at that value on a further hit rather than wrapping.
- R7: `rd_hot` is 1 exactly when the selected entry is valid and its count is strictly greater than `threshold`. It follows a change of `threshold` without a clock edge.
- R8: When all entries are valid, a discontinuity to an unmatched address changes no entry and sets `overflow`. `overflow` then stays 1 until reset, while hits to existing entries keep counting.
- R9: A valid PC identical to the previous valid PC counts as a discontinuity (difference 0, not 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 1 | A committed PC is present this cycle |
| pc | input | ADDR_W | Committed program counter |
| threshold | input | CNT_W | Hot limit; hot means count > threshold |
| rd_idx | input | IDX_W | Table entry selected for read-out |
| rd_valid | output | 1 | Selected entry holds a block |
| rd_addr | output | ADDR_W | Start address of the selected entry |
| rd_count | output | CNT_W | Execution count of the selected entry |
| rd_hot | output | 1 | Selected entry is hot |
| overflow | output | 1 | Sticky: an address was dropped on a full table |

## Verification
The hardest state to reach is a full table that then receives a new address while its counters sit at saturation. The bench builds it step by step. It uses a four-entry, four-bit-counter build. It hammers one address with a long run of identical PCs until the count pins at 15. Further jumps fill the remaining slots, and one more distinct target must be dropped. The bench then reads every entry back through the index port to confirm nothing moved. A last hit to an existing entry shows that counting still works after the overflow.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

    // Fixed instruction length in bytes: sequential PCs step by this amount.
    localparam int unsigned INSN_BYTES = 4;

    // What the table did in a given cycle.
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_HIT    = 2'd1,
        EV_INSERT = 2'd2,
        EV_DROP   = 2'd3
    } hbb_event_e;

endpackage

// File: rtl/hbb_disc_detect.sv
module hbb_disc_detect #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              disc_o
);
    import hbb_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] prev_pc;
        logic              have_prev;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pc_valid_i) begin
            st_d.prev_pc   = pc_i;
            st_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disc_o = pc_valid_i && st_q.have_prev && (pc_i != st_q.prev_pc + STEP);

    // R2: an idle cycle leaves the remembered PC untouched
    p_prev_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid_i |=> $stable(st_q.prev_pc));

endmodule

// File: rtl/hbb_match.sv
module hbb_match #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             vld_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0]              pc_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o,
    output logic                           free_o,
    output logic [IDX_W-1:0]               free_idx_o
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld_i[g] && (addr_i[g] == pc_i);
    end

    // Descending scan so the lowest-numbered candidate wins.
    always_comb begin
        hit_o      = 1'b0;
        hit_idx_o  = '0;
        free_o     = 1'b0;
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit_o     = 1'b1;
                hit_idx_o = IDX_W'(i);
            end
            if (!vld_i[i]) begin
                free_o     = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
    end

    // R5: a single address can occupy at most one entry
    p_unique_r5: assert final ($onehot0(eq));

endmodule

// File: rtl/hbb_profiler.sv
module hbb_profiler #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [CNT_W-1:0]  threshold,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_count,
    output logic              rd_hot,
    output logic              overflow
);
    import hbb_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][CNT_W-1:0]  cnt;
        logic                           ovf;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    hbb_event_e ev;

    logic             disc;
    logic             hit;
    logic             free;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;

    hbb_disc_detect #(.ADDR_W(ADDR_W)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_valid_i (pc_valid),
        .pc_i       (pc),
        .disc_o     (disc)
    );

    hbb_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_match (
        .vld_i      (st_q.vld),
        .addr_i     (st_q.addr),
        .pc_i       (pc),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .free_o     (free),
        .free_idx_o (free_idx)
    );

    always_comb begin
        st_d = st_q;
        ev   = EV_NONE;
        if (disc) begin
            if (hit) begin
                ev = EV_HIT;
                if (st_q.cnt[hit_idx] != CNT_MAX)
                    st_d.cnt[hit_idx] = st_q.cnt[hit_idx] + CNT_W'(1);
            end else if (free) begin
                ev = EV_INSERT;
                st_d.vld[free_idx]  = 1'b1;
                st_d.addr[free_idx] = pc;
                st_d.cnt[free_idx]  = CNT_W'(1);
            end else begin
                ev = EV_DROP;
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic rd_in_range;
    assign rd_in_range = (32'(rd_idx) < ENTRIES);

    always_comb begin
        rd_valid = 1'b0;
        rd_addr  = '0;
        rd_count = '0;
        if (rd_in_range) begin
            rd_valid = st_q.vld[rd_idx];
            rd_addr  = st_q.addr[rd_idx];
            rd_count = st_q.cnt[rd_idx];
        end
    end

    assign rd_hot   = rd_valid && (rd_count > threshold);
    assign overflow = st_q.ovf;

    // R8: overflow never clears once raised
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    // R8: overflow can only rise when every slot is occupied
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> (&st_q.vld));

    // R4: an insertion lands with a count of one
    p_insert_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_INSERT) |=> (st_q.vld[$past(free_idx)] && st_q.cnt[$past(free_idx)] == CNT_W'(1)));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R6: a saturated counter stays saturated
        p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cnt[g] == CNT_MAX) |=> (st_q.cnt[g] == CNT_MAX));
        // R5: a valid entry keeps its address and never loses count
        p_entry_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.vld[g] |=> (st_q.vld[g] && $stable(st_q.addr[g]) && st_q.cnt[g] >= $past(st_q.cnt[g])));
    end

endmodule

// File: tb/hbb_profiler_tb.sv
module hbb_profiler_tb;
    localparam int unsigned AW = 32;
    localparam int unsigned NE = 4;
    localparam int unsigned CW = 4;
    localparam int unsigned IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pc_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [CW-1:0] threshold = '0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] rd_count;
    logic          rd_hot;
    logic          overflow;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    hbb_profiler #(.ADDR_W(AW), .ENTRIES(NE), .CNT_W(CW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_valid  (pc_valid),
        .pc        (pc),
        .threshold (threshold),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_count  (rd_count),
        .rd_hot    (rd_hot),
        .overflow  (overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [AW-1:0] p);
        @(negedge clk);
        pc_valid = v;
        pc       = p;
        @(posedge clk);
        #1;
        pc_valid = 1'b0;
    endtask

    task automatic sel(input int i);
        rd_idx = IW'(i);
        #0.5;
    endtask

    task automatic chk_entry(input string req, input int i, input logic v,
                             input logic [AW-1:0] a, input logic [CW-1:0] c);
        sel(i);
        chk(req, 32'(rd_valid), 32'(v));
        chk(req, rd_addr, a);
        chk(req, 32'(rd_count), 32'(c));
    endtask

    task automatic t_reset_r1();
        for (int i = 0; i < NE; i++) chk_entry("R1 reset entry", i, 1'b0, '0, '0);
        chk("R1 hot", 32'(rd_hot), 0);
        chk("R1 overflow", 32'(overflow), 0);
    endtask

    task automatic t_first_r3();
        step(1'b1, 32'h100);
        for (int i = 0; i < NE; i++) chk_entry("R3 first pc", i, 1'b0, '0, '0);
    endtask

    task automatic t_seq_r2();
        step(1'b1, 32'h104);
        step(1'b1, 32'h108);
        step(1'b0, 32'h500);
        step(1'b1, 32'h10C);
        for (int i = 0; i < NE; i++) chk_entry("R2 sequential", i, 1'b0, '0, '0);
    endtask

    task automatic t_insert_r4();
        step(1'b1, 32'h200);
        chk_entry("R4 insert slot0", 0, 1'b1, 32'h200, 4'd1);
        step(1'b1, 32'h204);
        chk_entry("R4 seq after insert", 0, 1'b1, 32'h200, 4'd1);
        step(1'b1, 32'h300);
        chk_entry("R4 insert slot1", 1, 1'b1, 32'h300, 4'd1);
        chk_entry("R4 slot2 empty", 2, 1'b0, '0, '0);
    endtask

    task automatic t_hit_r5_r9();
        step(1'b1, 32'h200);
        chk_entry("R5 hit", 0, 1'b1, 32'h200, 4'd2);
        step(1'b1, 32'h200);
        chk_entry("R9 same pc", 0, 1'b1, 32'h200, 4'd3);
        chk_entry("R5 other untouched", 1, 1'b1, 32'h300, 4'd1);
    endtask

    task automatic t_hot_r7();
        sel(0);
        threshold = 4'd3;
        #0.5;
        chk("R7 equal not hot", 32'(rd_hot), 0);
        threshold = 4'd2;
        #0.5;
        chk("R7 above hot", 32'(rd_hot), 1);
        sel(2);
        threshold = 4'd0;
        #0.5;
        chk("R7 invalid not hot", 32'(rd_hot), 0);
    endtask

    task automatic t_sat_r6();
        for (int k = 0; k < 20; k++) step(1'b1, 32'h200);
        chk_entry("R6 saturate", 0, 1'b1, 32'h200, 4'hF);
        sel(0);
        threshold = 4'hE;
        #0.5;
        chk("R7 hot at max", 32'(rd_hot), 1);
    endtask

    task automatic t_full_r8();
        step(1'b1, 32'h400);
        step(1'b1, 32'h500);
        chk_entry("R8 fill slot2", 2, 1'b1, 32'h400, 4'd1);
        chk_entry("R8 fill slot3", 3, 1'b1, 32'h500, 4'd1);
        chk("R8 no overflow yet", 32'(overflow), 0);
        step(1'b1, 32'h600);
        chk("R8 overflow set", 32'(overflow), 1);
        chk_entry("R8 keep0", 0, 1'b1, 32'h200, 4'hF);
        chk_entry("R8 keep1", 1, 1'b1, 32'h300, 4'd1);
        chk_entry("R8 keep2", 2, 1'b1, 32'h400, 4'd1);
        chk_entry("R8 keep3", 3, 1'b1, 32'h500, 4'd1);
        step(1'b1, 32'h300);
        chk_entry("R8 hit after full", 1, 1'b1, 32'h300, 4'd2);
        step(1'b1, 32'h200);
        chk_entry("R6 sat after full", 0, 1'b1, 32'h200, 4'hF);
        chk("R8 overflow sticky", 32'(overflow), 1);
    endtask

    initial begin
        #(4 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #9;
        t_reset_r1();
        @(negedge clk);
        rst_n = 1'b1;
        t_first_r3();
        t_seq_r2();
        t_insert_r4();
        t_hit_r5_r9();
        t_hot_r7();
        t_sat_r6();
        t_full_r8();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule